// File: doc/BRIEF.md
# Fractional Payload Splitter for DS3/E3 Streams

This block divides the payload bits of a serial DS3/E3 stream into two shares, one bit at a time. The cell/packet share carries traffic. The remaining bits are fractional overhead. On the receive side, every payload-qualified bit goes either to the cell/packet processor output or to a serial overhead output. Each output has its own strobe.

On the transmit side, the block asks the cell/packet processor for a bit whenever a slot falls into the traffic share. It fills the other slots with overhead, then emits a single merged stream. Overhead fill can be constant zeros, constant ones, an alternating pattern, or bits from an external serial input.

The split between the two shares has two modes. In counter mode, a repeating run of programmable lengths sets it. In external mode, a per-bit select pin sets it. Framing and line coding happen elsewhere: the block only sees a payload-valid qualifier for each direction.

Top module: `frac_payload_split`

## Requirements
- R1: While reset is asserted, and until the first payload-valid cycle after it, every strobe, request and data output is 0.
- R2: In counter mode (`cfg_ext_alloc`=0), payload-valid bits are classed as a repeating sequence. It starts after reset with `cfg_pay_len` traffic bits, followed by `cfg_ovh_len` overhead bits.
- R3: In counter mode, `cfg_ovh_len`=0 classes every bit as traffic. `cfg_pay_len`=0 together with a nonzero `cfg_ovh_len` classes every bit as overhead.
- R4: Cycles without payload-valid produce no strobe and do not advance the allocation sequence.
- R5: In external mode (`cfg_ext_alloc`=1), a select pin sampled high on a payload-valid cycle classes that bit as overhead. Sampled low, it classes the bit as traffic. Receive uses `rx_sel` and transmit uses `tx_sel`.
- R6: A receive bit present with `rx_valid` appears one cycle later on `rx_pay_bit` with `rx_pay_stb`, or on `rx_ovh_bit` with `rx_ovh_stb`, according to its class. Exactly one strobe rises for it, and a data output reads 0 whenever its strobe is low.
- R7: `tx_pay_req` is high in the same cycle as a `tx_valid` slot classed as traffic. `tx_pay_in` is sampled in the following cycle.
- R8: The overhead fill is chosen by `cfg_ovh_src`: 0 gives zeros, 1 gives ones, 2 gives the alternating pattern, and 3 gives `tx_ovh_in` sampled in the slot cycle.
- R9: The alternating pattern gives 1 on the first transmit overhead slot after reset. It toggles once per transmit overhead slot, whichever fill is selected.
- R10: Every `tx_valid` slot produces its merged bit on `tx_bit` with `tx_stb` exactly two cycles later, and `tx_stb` is low otherwise.
- R11: `tx_ovh_req` is high in the same cycle as a `tx_valid` slot classed as overhead, and never together with `tx_pay_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_ext_alloc | input | 1 | 1 = select pins decide the split, 0 = counters decide |
| cfg_pay_len | input | LEN_W | Traffic bits per allocation run |
| cfg_ovh_len | input | LEN_W | Overhead bits per allocation run |
| cfg_ovh_src | input | 2 | Transmit overhead fill: 0 zeros, 1 ones, 2 alternating, 3 external |
| rx_valid | input | 1 | Receive payload-bit qualifier |
| rx_bit | input | 1 | Receive payload bit |
| rx_sel | input | 1 | Receive class select in external mode (1 = overhead) |
| rx_pay_bit | output | 1 | Traffic bit to cell/packet processor |
| rx_pay_stb | output | 1 | Strobe for rx_pay_bit |
| rx_ovh_bit | output | 1 | Serial overhead output bit |
| rx_ovh_stb | output | 1 | Strobe for rx_ovh_bit |
| tx_valid | input | 1 | Transmit payload-slot qualifier |
| tx_sel | input | 1 | Transmit class select in external mode (1 = overhead) |
| tx_pay_req | output | 1 | Request for a traffic bit, supplied next cycle |
| tx_pay_in | input | 1 | Traffic bit from cell/packet processor |
| tx_ovh_req | output | 1 | Marks an overhead slot this cycle |
| tx_ovh_in | input | 1 | External serial overhead bit |
| tx_bit | output | 1 | Merged transmit payload bit |
| tx_stb | output | 1 | Strobe for tx_bit |

## Verification
The assertions assume that configuration inputs change only while reset is held. For example, the zero-fill and no-overhead properties relate a configuration value to an outcome one or two cycles later. They also assume that a select pin is meaningful only on qualified cycles. The stimulus programs each configuration with reset asserted, then releases reset and waits for the internal release before raising any qualifier. It then randomises the qualifiers, the data bits and the select pins freely within each phase. Qualifier density differs from phase to phase, so that skipped bit times fall at varied points of the allocation run.

// File: rtl/frac_pkg.sv
package frac_pkg;
  typedef enum logic [1:0] {
    OVH_ZERO = 2'd0,
    OVH_ONE  = 2'd1,
    OVH_ALT  = 2'd2,
    OVH_EXT  = 2'd3
  } ovh_src_e;
endpackage

// File: rtl/frac_alloc.sv
module frac_alloc #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             ext_mode,
  input  logic             ext_sel,
  input  logic [LEN_W-1:0] pay_len,
  input  logic [LEN_W-1:0] ovh_len,
  output logic             is_ovh
);
  logic             in_ovh_q, in_ovh_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] limit;
  logic             last_bit;
  logic             ctr_ovh;
  logic             run_en;

  assign limit    = in_ovh_q ? ovh_len : pay_len;
  assign last_bit = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit};
  assign ctr_ovh  = (ovh_len != '0) && ((pay_len == '0) || in_ovh_q);
  assign is_ovh   = ext_mode ? ext_sel : ctr_ovh;
  assign run_en   = adv && !ext_mode;

  always_comb begin
    cnt_d    = cnt_q;
    in_ovh_d = in_ovh_q;
    if (last_bit) begin
      cnt_d    = '0;
      in_ovh_d = !in_ovh_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      in_ovh_q <= 1'b0;
    end else if (run_en) begin
      cnt_q    <= cnt_d;
      in_ovh_q <= in_ovh_d;
    end
  end
endmodule

// File: rtl/frac_pattern.sv
module frac_pattern
  import frac_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic [1:0] src,
  input  logic       ext_bit,
  output logic       ovh_bit
);
  logic alt_q, alt_d;

  assign alt_d = !alt_q;

  always_comb begin
    case (src)
      OVH_ZERO: ovh_bit = 1'b0;
      OVH_ONE:  ovh_bit = 1'b1;
      OVH_ALT:  ovh_bit = alt_q;
      default:  ovh_bit = ext_bit;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     alt_q <= 1'b1;
    else if (step)  alt_q <= alt_d;
  end
endmodule

// File: rtl/frac_rx_demap.sv
module frac_rx_demap (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic bit_in,
  input  logic is_ovh,
  output logic pay_bit,
  output logic pay_stb,
  output logic ovh_bit,
  output logic ovh_stb
);
  logic pay_take, ovh_take;
  logic pay_bit_d, ovh_bit_d;

  always_comb begin
    pay_take  = valid && !is_ovh;
    ovh_take  = valid && is_ovh;
    pay_bit_d = pay_take && bit_in;
    ovh_bit_d = ovh_take && bit_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pay_stb <= 1'b0;
      ovh_stb <= 1'b0;
      pay_bit <= 1'b0;
      ovh_bit <= 1'b0;
    end else begin
      pay_stb <= pay_take;
      ovh_stb <= ovh_take;
      pay_bit <= pay_bit_d;
      ovh_bit <= ovh_bit_d;
    end
  end
endmodule

// File: rtl/frac_tx_map.sv
module frac_tx_map (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  input  logic is_ovh,
  input  logic fill_bit,
  input  logic pay_in,
  output logic pay_req,
  output logic ovh_req,
  output logic tx_bit,
  output logic tx_stb
);
  logic slot_q, pay_q, fill_q;
  logic bit_d, stb_d;

  assign pay_req = valid && !is_ovh;
  assign ovh_req = valid && is_ovh;

  always_comb begin
    stb_d = slot_q;
    bit_d = slot_q && (pay_q ? pay_in : fill_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= 1'b0;
      pay_q  <= 1'b0;
      fill_q <= 1'b0;
    end else begin
      slot_q <= valid;
      pay_q  <= pay_req;
      fill_q <= ovh_req && fill_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_stb <= 1'b0;
      tx_bit <= 1'b0;
    end else begin
      tx_stb <= stb_d;
      tx_bit <= bit_d;
    end
  end
endmodule

// File: rtl/frac_payload_split.sv
module frac_payload_split #(
  parameter int LEN_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_ext_alloc,
  input  logic [LEN_W-1:0] cfg_pay_len,
  input  logic [LEN_W-1:0] cfg_ovh_len,
  input  logic [1:0]       cfg_ovh_src,
  input  logic             rx_valid,
  input  logic             rx_bit,
  input  logic             rx_sel,
  output logic             rx_pay_bit,
  output logic             rx_pay_stb,
  output logic             rx_ovh_bit,
  output logic             rx_ovh_stb,
  input  logic             tx_valid,
  input  logic             tx_sel,
  output logic             tx_pay_req,
  input  logic             tx_pay_in,
  output logic             tx_ovh_req,
  input  logic             tx_ovh_in,
  output logic             tx_bit,
  output logic             tx_stb
);
  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0] sync_q;
  logic              rst_sync_n;
  logic              rx_is_ovh, tx_is_ovh;
  logic              fill_bit;
  logic              alt_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_MSB-1:0], 1'b1};
  end
  assign rst_sync_n = sync_q[SYNC_MSB];

  frac_alloc #(.LEN_W(LEN_W)) u_rx_alloc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .adv      (rx_valid),
    .ext_mode (cfg_ext_alloc),
    .ext_sel  (rx_sel),
    .pay_len  (cfg_pay_len),
    .ovh_len  (cfg_ovh_len),
    .is_ovh   (rx_is_ovh)
  );

  frac_alloc #(.LEN_W(LEN_W)) u_tx_alloc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .adv      (tx_valid),
    .ext_mode (cfg_ext_alloc),
    .ext_sel  (tx_sel),
    .pay_len  (cfg_pay_len),
    .ovh_len  (cfg_ovh_len),
    .is_ovh   (tx_is_ovh)
  );

  frac_rx_demap u_rx (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .valid   (rx_valid),
    .bit_in  (rx_bit),
    .is_ovh  (rx_is_ovh),
    .pay_bit (rx_pay_bit),
    .pay_stb (rx_pay_stb),
    .ovh_bit (rx_ovh_bit),
    .ovh_stb (rx_ovh_stb)
  );

  assign alt_step = tx_valid && tx_is_ovh;

  frac_pattern u_fill (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .step    (alt_step),
    .src     (cfg_ovh_src),
    .ext_bit (tx_ovh_in),
    .ovh_bit (fill_bit)
  );

  frac_tx_map u_tx (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .valid    (tx_valid),
    .is_ovh   (tx_is_ovh),
    .fill_bit (fill_bit),
    .pay_in   (tx_pay_in),
    .pay_req  (tx_pay_req),
    .ovh_req  (tx_ovh_req),
    .tx_bit   (tx_bit),
    .tx_stb   (tx_stb)
  );
endmodule

// File: rtl/frac_payload_split_chk.sv
module frac_payload_split_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_ext_alloc,
  input logic [LEN_W-1:0] cfg_ovh_len,
  input logic [1:0]       cfg_ovh_src,
  input logic             rx_valid,
  input logic             rx_sel,
  input logic             rx_pay_stb,
  input logic             rx_ovh_stb,
  input logic             tx_valid,
  input logic             tx_pay_req,
  input logic             tx_ovh_req,
  input logic             tx_bit,
  input logic             tx_stb
);
  assert_one_dest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_pay_stb, rx_ovh_stb}));

  assert_rx_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> (rx_pay_stb || rx_ovh_stb));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> (!rx_pay_stb && !rx_ovh_stb));

  assert_ext_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ext_alloc && rx_valid && rx_sel) |=> rx_ovh_stb);

  assert_no_ovh_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ext_alloc && cfg_ovh_len == '0 && rx_valid) |=> rx_pay_stb);

  assert_req_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_pay_req && tx_ovh_req));

  assert_req_qual_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pay_req || tx_ovh_req) |-> tx_valid);

  assert_tx_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> ##1 tx_stb);

  assert_tx_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |=> ##1 !tx_stb);

  assert_zero_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovh_req && cfg_ovh_src == 2'd0) |=> ##1 (tx_stb && !tx_bit));
endmodule

bind frac_payload_split frac_payload_split_chk #(.LEN_W(LEN_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .cfg_ext_alloc (cfg_ext_alloc),
  .cfg_ovh_len   (cfg_ovh_len),
  .cfg_ovh_src   (cfg_ovh_src),
  .rx_valid      (rx_valid),
  .rx_sel        (rx_sel),
  .rx_pay_stb    (rx_pay_stb),
  .rx_ovh_stb    (rx_ovh_stb),
  .tx_valid      (tx_valid),
  .tx_pay_req    (tx_pay_req),
  .tx_ovh_req    (tx_ovh_req),
  .tx_bit        (tx_bit),
  .tx_stb        (tx_stb)
);

// File: tb/frac_payload_split_test.sv
module frac_payload_split_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_ext_alloc;
  logic [7:0] cfg_pay_len, cfg_ovh_len;
  logic [1:0] cfg_ovh_src;
  logic       rx_valid, rx_bit, rx_sel;
  logic       rx_pay_bit, rx_pay_stb, rx_ovh_bit, rx_ovh_stb;
  logic       tx_valid, tx_sel, tx_pay_req, tx_pay_in, tx_ovh_req, tx_ovh_in;
  logic       tx_bit, tx_stb;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  frac_payload_split uut (
    .clk(clk), .rst_n(rst_n), .cfg_ext_alloc(cfg_ext_alloc),
    .cfg_pay_len(cfg_pay_len), .cfg_ovh_len(cfg_ovh_len), .cfg_ovh_src(cfg_ovh_src),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .rx_sel(rx_sel),
    .rx_pay_bit(rx_pay_bit), .rx_pay_stb(rx_pay_stb),
    .rx_ovh_bit(rx_ovh_bit), .rx_ovh_stb(rx_ovh_stb),
    .tx_valid(tx_valid), .tx_sel(tx_sel), .tx_pay_req(tx_pay_req),
    .tx_pay_in(tx_pay_in), .tx_ovh_req(tx_ovh_req), .tx_ovh_in(tx_ovh_in),
    .tx_bit(tx_bit), .tx_stb(tx_stb)
  );

  // reference model state
  int rx_pos, tx_pos;
  bit alt;
  bit a_v, a_pay, a_fill;
  bit e_rpb, e_rps, e_rob, e_ros, e_tb, e_ts;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit classify(bit ext, bit sel, int pos);
    if (ext) return sel;
    return (cfg_ovh_len != 0) && (cfg_pay_len == 0 || pos >= int'(cfg_pay_len));
  endfunction

  function automatic int wrap(int pos);
    int period = int'(cfg_pay_len) + int'(cfg_ovh_len);
    if (period == 0) return 0;
    return (pos + 1) % period;
  endfunction

  task automatic model_edge();
    bit rc, tc, fill;
    rc = classify(cfg_ext_alloc, rx_sel, rx_pos);
    tc = classify(cfg_ext_alloc, tx_sel, tx_pos);
    e_rps = rx_valid && !rc;
    e_ros = rx_valid && rc;
    e_rpb = e_rps && rx_bit;
    e_rob = e_ros && rx_bit;
    if (rx_valid && !cfg_ext_alloc) rx_pos = wrap(rx_pos);
    e_ts = a_v;
    e_tb = a_v && (a_pay ? tx_pay_in : a_fill);
    case (cfg_ovh_src)
      2'd0: fill = 1'b0;
      2'd1: fill = 1'b1;
      2'd2: fill = alt;
      default: fill = tx_ovh_in;
    endcase
    a_v    = tx_valid;
    a_pay  = tx_valid && !tc;
    a_fill = tx_valid && tc && fill;
    if (tx_valid && tc) alt = !alt;
    if (tx_valid && !cfg_ext_alloc) tx_pos = wrap(tx_pos);
  endtask

  task automatic compare(string tag);
    chk({tag, " R6"},  "rx_pay_stb", rx_pay_stb, e_rps);
    chk({tag, " R6"},  "rx_pay_bit", rx_pay_bit, e_rpb);
    chk({tag, " R6"},  "rx_ovh_stb", rx_ovh_stb, e_ros);
    chk({tag, " R6"},  "rx_ovh_bit", rx_ovh_bit, e_rob);
    chk({tag, " R10"}, "tx_stb",     tx_stb,     e_ts);
    chk({tag, " R8"},  "tx_bit",     tx_bit,     e_tb);
  endtask

  task automatic idle_inputs();
    rx_valid = 0; rx_bit = 0; rx_sel = 0;
    tx_valid = 0; tx_sel = 0; tx_pay_in = 0; tx_ovh_in = 0;
  endtask

  task automatic run_phase(string tag, int p, int o, bit ext, logic [1:0] src,
                           int n, int vpct);
    @(negedge clk);
    rst_n = 0;
    idle_inputs();
    cfg_pay_len = 8'(p); cfg_ovh_len = 8'(o);
    cfg_ext_alloc = ext; cfg_ovh_src = src;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1", "outputs in reset",
        {26'd0, rx_pay_stb, rx_ovh_stb, rx_pay_bit, rx_ovh_bit, tx_stb, tx_bit}, 0);
    chk("R1", "requests in reset", {30'd0, tx_pay_req, tx_ovh_req}, 0);
    rst_n = 1;
    rx_pos = 0; tx_pos = 0; alt = 1;
    a_v = 0; a_pay = 0; a_fill = 0;
    e_rpb = 0; e_rps = 0; e_rob = 0; e_ros = 0; e_tb = 0; e_ts = 0;
    repeat (4) @(negedge clk);
    chk("R1", "outputs after release",
        {26'd0, rx_pay_stb, rx_ovh_stb, rx_pay_bit, rx_ovh_bit, tx_stb, tx_bit}, 0);
    for (int i = 0; i < n + 3; i++) begin
      bit tc;
      if (i > 0) compare(tag);
      if (i < n) begin
        rx_valid  = ($urandom % 100) < vpct;
        tx_valid  = ($urandom % 100) < vpct;
        rx_bit    = $urandom;
        rx_sel    = $urandom;
        tx_sel    = $urandom;
        tx_pay_in = $urandom;
        tx_ovh_in = $urandom;
      end else begin
        idle_inputs();
      end
      #1;
      tc = classify(cfg_ext_alloc, tx_sel, tx_pos);
      chk({tag, " R7"},  "tx_pay_req", tx_pay_req, tx_valid && !tc);
      chk({tag, " R11"}, "tx_ovh_req", tx_ovh_req, tx_valid && tc);
      @(posedge clk);
      model_edge();
      @(negedge clk);
    end
  endtask

  task automatic first_alt_check();
    // R9: first overhead slot after reset carries a 1 under alternating fill
    @(negedge clk);
    rst_n = 0; idle_inputs();
    cfg_ext_alloc = 0; cfg_pay_len = 8'd0; cfg_ovh_len = 8'd2; cfg_ovh_src = 2'd2;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    tx_valid = 1;
    @(negedge clk);
    tx_valid = 0;
    @(negedge clk);
    chk("R9", "first alternating bit", {30'd0, tx_stb, tx_bit}, 3);
    tx_valid = 1;
    @(negedge clk);
    tx_valid = 0;
    @(negedge clk);
    chk("R9", "second alternating bit", {30'd0, tx_stb, tx_bit}, 2);
  endtask

  initial begin
    rst_n = 0;
    cfg_ext_alloc = 0; cfg_pay_len = 0; cfg_ovh_len = 0; cfg_ovh_src = 0;
    idle_inputs();
    run_phase("R2 R9 counter 5/3 alternating",   5,   3, 0, 2'd2, 1500, 80);
    run_phase("R3 all overhead ones",            0,   4, 0, 2'd1,  600, 70);
    run_phase("R3 no overhead zeros",            7,   0, 0, 2'd0,  600, 70);
    run_phase("R4 sparse valid counter 2/6",     2,   6, 0, 2'd3, 1500, 30);
    run_phase("R5 external select",              9,   9, 1, 2'd3, 1500, 75);
    run_phase("R2 long run 255/255",           255, 255, 0, 2'd2, 2500, 90);
    run_phase("R8 zero fill counter 1/1",        1,   1, 0, 2'd0,  600, 100);
    first_alt_check();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule